// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the memory-array address for every cycle of a four-beat burst. A load cycle captures an external address while the chip is selected and opens a burst. Each following advance cycle moves the two lowest address bits one step through the chosen order, while the upper bits keep the loaded value. A static order input picks linear stepping (start plus beat count, modulo four) or interleaved stepping (start XOR beat count). Both orders wrap to the start value after the fourth beat and keep cycling for as long as advance stays asserted.

A load while the chip is deselected closes the burst and leaves the address where it was. A new load during a burst replaces the burst at once. A high freeze input makes the clock edge invisible to the block, so all of its state holds. The output address and the burst flag come straight from registers, through the low-bit combiner only, so a load or step shows on the port one clock after the edge that samples it.

Top module: `burst_addr_seq`

## Requirements
- R1: During synchronous reset (rst_n low at a rising edge) mem_addr becomes 0 and burst_on becomes 0.
- R2: An edge with freeze=0, load_n=0 and sel=1 makes mem_addr equal the sampled ext_addr and burst_on=1 after that edge.
- R3: With order_sel=0 (linear), the k-th advance after a load gives mem_addr[1:0] = (start + k) mod 4, where start is the loaded value of bits [1:0]. A start of 01 gives 01, 10, 11, 00.
- R4: With order_sel=1 (interleaved), the k-th advance gives mem_addr[1:0] = start XOR (k mod 4). A start of 01 gives 01, 00, 11, 10.
- R5: After the fourth beat the low bits return to the start value and keep cycling while advances continue.
- R6: During advance cycles (load_n=1), mem_addr[ADDR_W-1:2] keeps the loaded value and ext_addr has no effect.
- R7: An edge with freeze=0, load_n=0 and sel=0 sets burst_on to 0 and leaves mem_addr unchanged.
- R8: A load during an active burst starts a new burst at the new address on the next cycle, with the beat count restarted.
- R9: An edge with freeze=1 leaves mem_addr and burst_on unchanged, whatever the other inputs are.
- R10: An advance edge (load_n=1, freeze=0) while burst_on=0 leaves mem_addr unchanged and burst_on at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| freeze | input | 1 | High: the edge is ignored and all state holds |
| load_n | input | 1 | Low: load (or close the burst when deselected). High: advance |
| sel | input | 1 | Combined chip-select result, high when selected |
| order_sel | input | 1 | Static burst order: 0 linear, 1 interleaved |
| ext_addr | input | ADDR_W | External address, sampled on load cycles |
| mem_addr | output | ADDR_W | Current address to the memory array |
| burst_on | output | 1 | High while a burst is open |

## Verification
A wrong beat count or start value shows on mem_addr[1:0] on the first advance after the fault, and an upper-bit corruption appears in the same cycle that the base register takes it. A lost or stuck burst flag shows on burst_on one edge after the load or deselect that should have changed it, and on mem_addr at the next advance that then steps or fails to step. A behavioural model in the bench is compared with both outputs on every clock, so a divergence is reported in the cycle in which it first reaches a port.

// File: rtl/burst_seq_pkg.sv
// Shared types for the burst address sequencer.
// Assumes a burst length that is a power of two.
package burst_seq_pkg;
    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } burst_order_e;
endpackage

// File: rtl/bseq_ctrl.sv
// Burst control: decides load and step events, holds the burst-open flag.
// Assumes freeze high blocks every state change in the sequencer.
module bseq_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic freeze,
    input  logic load_n,
    input  logic sel,
    output logic take_load,
    output logic step,
    output logic burst_on
);
    // Event decode from the sampled controls.
    always_comb begin
        take_load = !freeze && !load_n && sel;
        step      = !freeze && load_n && burst_on;
    end

    // Burst flag: opened by a selected load, closed by a deselected load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            burst_on <= 1'b0;
        end else if (!freeze && !load_n) begin
            burst_on <= sel;
        end
    end

    p_deselect_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!freeze && !load_n && !sel) |=> !burst_on);

    p_idle_adv_stays_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!freeze && load_n && !burst_on) |=> !burst_on);

    p_frozen_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        freeze |=> $stable(burst_on));
endmodule

// File: rtl/bseq_beat.sv
// Beat counter: cleared on load, incremented on each step, wraps naturally.
// Assumes clear and step are never asserted together.
module bseq_beat #(
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              step,
    output logic [BEAT_W-1:0] beat
);
    // Beat register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat <= '0;
        end else if (clear) begin
            beat <= '0;
        end else if (step) begin
            beat <= beat + 1'b1;
        end
    end

    p_beat_steps_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clear) |=> (beat == BEAT_W'($past(beat) + 1'b1)));

    p_beat_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (beat == '0));
endmodule

// File: rtl/bseq_base.sv
// Base address register: upper bits and burst start bits captured on load.
// Assumes ADDR_W is larger than BEAT_W.
module bseq_base #(
    parameter int ADDR_W = 17,
    parameter int BEAT_W = 2,
    localparam int HI_W  = ADDR_W - BEAT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_load,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [HI_W-1:0]   base_hi,
    output logic [BEAT_W-1:0] start
);
    // Capture the external address only on a load event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_hi <= '0;
            start   <= '0;
        end else if (take_load) begin
            base_hi <= ext_addr[ADDR_W-1:BEAT_W];
            start   <= ext_addr[BEAT_W-1:0];
        end
    end

    p_base_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !take_load |=> ($stable(base_hi) && $stable(start)));
endmodule

// File: rtl/bseq_mix.sv
// Low-bit combiner: start bits with beat count by modular add or bitwise XOR.
// Assumes the order input is static during a burst.
module bseq_mix #(
    parameter int BEAT_W = 2
) (
    input  logic [BEAT_W-1:0]        start,
    input  logic [BEAT_W-1:0]        beat,
    input  burst_seq_pkg::burst_order_e order,
    output logic [BEAT_W-1:0]        low
);
    logic [BEAT_W-1:0] lin_low;
    logic [BEAT_W-1:0] ilv_low;

    // Interleaved order: per-bit toggle of the start value.
    for (genvar b = 0; b < BEAT_W; b++) begin : g_ilv
        assign ilv_low[b] = start[b] ^ beat[b];
    end

    // Linear order and final selection.
    always_comb begin
        lin_low = start + beat;
        low     = (order == burst_seq_pkg::ORD_INTERLEAVE) ? ilv_low : lin_low;
    end
endmodule

// File: rtl/burst_addr_seq.sv
// Burst address sequencer top: joins control, beat counter, base register
// and low-bit combiner into the per-cycle array address.
// Assumes order_sel is static and freeze high blocks the whole edge.
module burst_addr_seq #(
    parameter int ADDR_W = 17,
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              freeze,
    input  logic              load_n,
    input  logic              sel,
    input  logic              order_sel,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              burst_on
);
    import burst_seq_pkg::*;
    localparam int HI_W = ADDR_W - BEAT_W;

    logic              take_load;
    logic              step;
    logic [BEAT_W-1:0] beat;
    logic [BEAT_W-1:0] start;
    logic [BEAT_W-1:0] low;
    logic [HI_W-1:0]   base_hi;
    burst_order_e      order;

    // Static order select mapped to the shared type.
    always_comb order = burst_order_e'(order_sel);

    bseq_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .freeze    (freeze),
        .load_n    (load_n),
        .sel       (sel),
        .take_load (take_load),
        .step      (step),
        .burst_on  (burst_on)
    );

    bseq_beat #(.BEAT_W(BEAT_W)) u_beat (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (take_load),
        .step  (step),
        .beat  (beat)
    );

    bseq_base #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_base (
        .clk       (clk),
        .rst_n     (rst_n),
        .take_load (take_load),
        .ext_addr  (ext_addr),
        .base_hi   (base_hi),
        .start     (start)
    );

    bseq_mix #(.BEAT_W(BEAT_W)) u_mix (
        .start (start),
        .beat  (beat),
        .order (order),
        .low   (low)
    );

    // Output address assembly.
    always_comb mem_addr = {base_hi, low};

    p_load_takes_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!freeze && !load_n && sel) |=> (mem_addr == $past(ext_addr) && burst_on));

    p_freeze_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        freeze |=> $stable(mem_addr));

    p_upper_fixed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!freeze && load_n) |=> $stable(mem_addr[ADDR_W-1:BEAT_W]));

    p_idle_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!freeze && load_n && !burst_on) |=> $stable(mem_addr));

    p_deselect_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!freeze && !load_n && !sel) |=> $stable(mem_addr));
endmodule

// File: tb/test_burst_addr_seq.sv
module test_burst_addr_seq;
    localparam int AW = 17;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          freeze = 1'b0;
    logic          load_n = 1'b1;
    logic          sel = 1'b0;
    logic          order_sel = 1'b0;
    logic [AW-1:0] ext_addr = '0;
    logic [AW-1:0] mem_addr;
    logic          burst_on;

    int checks = 0;
    int failures = 0;
    bit model_on = 1'b0;
    string cur_tag = "R1";
    bit done = 1'b0;

    // Reference state kept as plain integers.
    int m_base = 0;
    int m_k = 0;
    int m_on = 0;

    always #4 clk = ~clk;

    burst_addr_seq #(.ADDR_W(AW), .BEAT_W(2)) i_burst_addr_seq (
        .clk(clk), .rst_n(rst_n), .freeze(freeze), .load_n(load_n),
        .sel(sel), .order_sel(order_sel), .ext_addr(ext_addr),
        .mem_addr(mem_addr), .burst_on(burst_on)
    );

    function automatic int model_addr();
        int s;
        int lo;
        s = m_base % 4;
        if (order_sel) lo = s ^ (m_k % 4);
        else           lo = (s + m_k) % 4;
        return (m_base - s) + lo;
    endfunction

    // Behavioural model advanced on every rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_base = 0; m_k = 0; m_on = 0;
        end else if (!freeze) begin
            if (!load_n) begin
                if (sel) begin
                    m_base = int'(ext_addr); m_k = 0; m_on = 1;
                end else begin
                    m_on = 0;
                end
            end else if (m_on == 1) begin
                m_k = m_k + 1;
            end
        end
    end

    // Per-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        if (model_on && !done) begin
            checks++;
            if (int'(mem_addr) != model_addr() || int'(burst_on) != m_on) begin
                failures++;
                $display("FAIL %s model: addr=%h on=%0d expected addr=%h on=%0d",
                         cur_tag, mem_addr, burst_on, model_addr(), m_on);
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One clock: drive at negedge, return at the next negedge.
    task automatic cyc(input bit ld_n, input bit s, input bit frz, input int a);
        load_n = ld_n; sel = s; freeze = frz; ext_addr = AW'(a);
        @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(8 * 5000);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        // R1: reset state.
        chk("R1 addr", int'(mem_addr), 0);
        chk("R1 flag", int'(burst_on), 0);
        rst_n = 1'b1;
        model_on = 1'b1;

        // R10: advance with no burst open.
        cur_tag = "R10";
        cyc(1, 1, 0, 'h1ABCD);
        chk("R10 addr", int'(mem_addr), 0);
        chk("R10 flag", int'(burst_on), 0);

        // R2/R3/R5/R6: linear burst from start 01.
        cur_tag = "R2";
        order_sel = 1'b0;
        cyc(0, 1, 0, 'h12345);
        chk("R2 addr", int'(mem_addr), 'h12345);
        chk("R2 flag", int'(burst_on), 1);
        cur_tag = "R3";
        cyc(1, 1, 0, 'h0FFFF);
        chk("R3 beat1", int'(mem_addr[1:0]), 2);
        chk("R6 upper", int'(mem_addr[AW-1:2]), 'h12345 >> 2);
        cyc(1, 0, 0, 'h00002);
        chk("R3 beat2", int'(mem_addr[1:0]), 3);
        cyc(1, 1, 0, 'h1FFFF);
        chk("R3 beat3", int'(mem_addr[1:0]), 0);
        cur_tag = "R5";
        cyc(1, 1, 0, 'h0);
        chk("R5 wrap", int'(mem_addr[1:0]), 1);
        cyc(1, 1, 0, 'h0);
        chk("R5 continue", int'(mem_addr[1:0]), 2);
        chk("R6 upper after wrap", int'(mem_addr[AW-1:2]), 'h12345 >> 2);

        // R4/R5: interleaved burst from start 01.
        cur_tag = "R4";
        order_sel = 1'b1;
        cyc(0, 1, 0, 'h0A5F1);
        chk("R4 load", int'(mem_addr), 'h0A5F1);
        cyc(1, 1, 0, 'h0);
        chk("R4 beat1", int'(mem_addr[1:0]), 0);
        cyc(1, 1, 0, 'h0);
        chk("R4 beat2", int'(mem_addr[1:0]), 3);
        cyc(1, 1, 0, 'h0);
        chk("R4 beat3", int'(mem_addr[1:0]), 2);
        cyc(1, 1, 0, 'h0);
        chk("R5 ilv wrap", int'(mem_addr[1:0]), 1);

        // R8: new load mid-burst restarts at once.
        cur_tag = "R8";
        cyc(1, 1, 0, 'h0);
        cyc(0, 1, 0, 'h15552);
        chk("R8 reload", int'(mem_addr), 'h15552);
        cyc(1, 1, 0, 'h0);
        chk("R8 first step", int'(mem_addr), 'h15553);

        // R9: freeze blocks loads and steps.
        cur_tag = "R9";
        cyc(0, 1, 1, 'h00444);
        chk("R9 load blocked", int'(mem_addr), 'h15553);
        cyc(1, 1, 1, 'h0);
        cyc(0, 0, 1, 'h0);
        chk("R9 step blocked", int'(mem_addr), 'h15553);
        chk("R9 flag", int'(burst_on), 1);
        cyc(1, 1, 0, 'h0);
        chk("R9 resume", int'(mem_addr), 'h15550);

        // R7: deselected load closes the burst, address holds.
        cur_tag = "R7";
        cyc(0, 0, 0, 'h07777);
        chk("R7 flag", int'(burst_on), 0);
        chk("R7 addr", int'(mem_addr), 'h15550);
        cur_tag = "R10";
        cyc(1, 1, 0, 'h0);
        chk("R10 after close", int'(mem_addr), 'h15550);
        chk("R10 flag after close", int'(burst_on), 0);

        // Mixed linear pattern with start 11.
        cur_tag = "R3";
        order_sel = 1'b0;
        cyc(0, 1, 0, 'h00003);
        for (int i = 1; i < 7; i++) begin
            cyc(1, 1, 0, i * 'h1111);
            chk("R3 start11", int'(mem_addr[1:0]), (3 + i) % 4);
        end

        // R1: reset mid-burst.
        cur_tag = "R1";
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 reset mid-burst", int'(mem_addr), 0);
        chk("R1 flag mid-burst", int'(burst_on), 0);
        rst_n = 1'b1;
        @(negedge clk);
        finish_run();
    end
endmodule